// File: doc/BRIEF.md
# PWM Time-Averaged Duty Estimator

This block turns a PWM gate signal that arrives with no timing relation to the local clock into an averaged switching value for a real-time converter model. The block samples the PWM once per fast clock cycle. A fixed simulation step spans `STEP_CYCLES` fast cycles. During each step, the block counts the cycles in which the sampled PWM was high. At the step boundary it scales that count into a fraction between zero and one. The converter model then uses this fraction as its switch state for the whole next step. The result does not depend on where a PWM edge falls between step boundaries, and no interpolation arithmetic is needed.

The block divides time into steps with an internal modulo-`STEP_CYCLES` cycle counter. It drives the boundary strobe out so that the model can advance in lockstep with the duty values. The default ratio is ten fast cycles per step. The duty output is signed 32-bit fixed point with 22 fractional bits.

The duty output carries only a valid pulse and has no ready input. A new value is produced once per step at a fixed rate, and there is no back-pressure. The consumer must take each value while it is held, which lasts until the next pulse.

Top module: `pwm_duty_avg`

## Requirements
- R1: `pwm_in` passes through a two-flop synchronizer. A level that is present at a rising edge is counted at the second rising edge after it, so the delay is a constant two cycles.
- R2: The high-time count increases by exactly one for each fast cycle in which the synchronized PWM is high. It does not change in cycles where the synchronized PWM is low.
- R3: `step_end` is a one-cycle pulse repeating every `STEP_CYCLES` cycles. Its first pulse is in the `STEP_CYCLES`-th cycle after reset is released.
- R4: The sample taken in the `step_end` cycle belongs to the step that is ending. The count then restarts from zero, so each cycle is counted in exactly one step.
- R5: `duty` equals the step's count times 2^22 divided by `STEP_CYCLES`, rounded to the nearest integer. It is signed two's complement with bits 21:0 as the fraction, and it never exceeds 0x0040_0000.
- R6: A step with PWM high in every counted cycle gives exactly 0x0040_0000 (1.0). A step with PWM low in every counted cycle gives exactly 0.
- R7: `duty_valid` pulses for one cycle in the cycle after each `step_end`, and `duty` takes its new value in that same cycle. In every other cycle, `duty` holds its value.
- R8: While `rst_n` is low, `duty` is 0, and `duty_valid` and `step_end` are 0. The synchronizer, the cycle counter and the high-time count restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | External PWM, asynchronous to clk |
| step_end | output | 1 | One-cycle pulse in the last cycle of each step |
| duty | output | 32 | Averaged duty, signed Q9.22 |
| duty_valid | output | 1 | One-cycle pulse when duty updates |

## Verification
The steps are stimulated with several patterns: all low, all high, a rising edge in mid-step, a falling edge in mid-step, alternating levels, and counts of 1, 3, 7 and 9. The odd counts separate correct rounding from truncation and from a coarse constant gain. A step high only in its last cycle, followed by a step high only in its first cycle, shows whether the boundary sample lands in the right step and whether the synchronizer delay is the stated two cycles. A reset applied while the PWM is high checks the restart state and the exact count of the first step after release.

// File: rtl/pwm_avg_pkg.sv
package pwm_avg_pkg;
  // width that holds values 0..n inclusive
  function automatic int span_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
  // width of an index running 0..n-1
  function automatic int index_width(input int n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/step_timer.sv
module step_timer
  import pwm_avg_pkg::*;
#(
  parameter int STEP_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic last_cycle
);
  localparam int IW = index_width(STEP_CYCLES);
  localparam logic [IW-1:0] LAST = IW'(STEP_CYCLES - 1);

  logic [IW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign last_cycle = rst_n && (phase_q == LAST);
endmodule

// File: rtl/high_counter.sv
module high_counter
  import pwm_avg_pkg::*;
#(
  parameter int STEP_CYCLES = 10,
  localparam int CW = span_width(STEP_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          close_step,
  output logic [CW-1:0] step_total
);
  logic [CW-1:0] acc_q;

  // the current sample is folded in before any clear
  assign step_total = acc_q + CW'(sample);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (close_step) acc_q <= '0;
    else                 acc_q <= step_total;
  end
endmodule

// File: rtl/duty_scale.sv
module duty_scale
  import pwm_avg_pkg::*;
#(
  parameter int STEP_CYCLES = 10,
  parameter int DUTY_W      = 32,
  parameter int FRAC_W      = 22,
  localparam int CW = span_width(STEP_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     count,
  input  logic              load,
  output logic [DUTY_W-1:0] duty,
  output logic              duty_valid
);
  localparam int PW = CW + FRAC_W + 1;
  localparam logic [PW-1:0] DIVISOR = PW'(STEP_CYCLES);
  localparam logic [PW-1:0] HALF    = PW'(STEP_CYCLES / 2);

  logic [PW-1:0] scaled;
  logic [PW-1:0] quotient;

  // count / STEP_CYCLES in Q.FRAC_W, rounded to nearest
  assign scaled   = (PW'(count) << FRAC_W) + HALF;
  assign quotient = scaled / DIVISOR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty       <= '0;
      duty_valid <= 1'b0;
    end else begin
      duty_valid <= load;
      if (load) duty <= DUTY_W'(quotient);
    end
  end
endmodule

// File: rtl/pwm_duty_avg.sv
module pwm_duty_avg
  import pwm_avg_pkg::*;
#(
  parameter int STEP_CYCLES = 10,
  parameter int SYNC_STAGES = 2,
  parameter int DUTY_W      = 32,
  parameter int FRAC_W      = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  output logic              step_end,
  output logic [DUTY_W-1:0] duty,
  output logic              duty_valid
);
  localparam int CW = span_width(STEP_CYCLES);

  logic          pwm_s;
  logic [CW-1:0] total;

  pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pwm_in), .d_sync(pwm_s)
  );

  step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .last_cycle(step_end)
  );

  high_counter #(.STEP_CYCLES(STEP_CYCLES)) u_count (
    .clk(clk), .rst_n(rst_n), .sample(pwm_s),
    .close_step(step_end), .step_total(total)
  );

  duty_scale #(
    .STEP_CYCLES(STEP_CYCLES), .DUTY_W(DUTY_W), .FRAC_W(FRAC_W)
  ) u_scale (
    .clk(clk), .rst_n(rst_n), .count(total), .load(step_end),
    .duty(duty), .duty_valid(duty_valid)
  );
endmodule

// File: rtl/pwm_duty_avg_chk.sv
module pwm_duty_avg_chk #(
  parameter int STEP_CYCLES = 10,
  parameter int DUTY_W      = 32,
  parameter int FRAC_W      = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_end,
  input logic [DUTY_W-1:0] duty,
  input logic              duty_valid
);
  localparam logic [DUTY_W-1:0] ONE = DUTY_W'(1) << FRAC_W;

  int unsigned gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= 0;
    else if (step_end) gap_q <= 0;
    else               gap_q <= gap_q + 1;
  end

  // R3: boundary strobe spacing counted by the checker
  a_r3_step_period: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |-> (gap_q == STEP_CYCLES - 1));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |=> !step_end);

  // R7: valid follows each boundary by one cycle
  a_r7_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |=> duty_valid);

  a_r7_valid_only_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    duty_valid |-> $past(step_end));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_valid |-> $stable(duty));

  // R5: duty lies in [0, 1.0]
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= ONE);
endmodule

bind pwm_duty_avg pwm_duty_avg_chk #(
  .STEP_CYCLES(STEP_CYCLES), .DUTY_W(DUTY_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .step_end(step_end),
  .duty(duty), .duty_valid(duty_valid)
);

// File: tb/pwm_duty_avg_test.sv
module pwm_duty_avg_test;
  localparam int K  = 10;
  localparam int NV = 12;

  // stimulus: bit i = level counted in cycle i of the step; expected Q22 duty
  localparam logic [K-1:0] V_MASK [NV] = '{
    10'h000, 10'h3FF, 10'h01F, 10'h3E0, 10'h200, 10'h001,
    10'h155, 10'h07F, 10'h1FF, 10'h007, 10'h3FF, 10'h000
  };
  localparam int V_DUTY [NV] = '{
    0, 4194304, 2097152, 2097152, 419430, 419430,
    2097152, 2936013, 3774874, 1258291, 4194304, 0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm_in = 1'b0;
  logic        step_end;
  logic [31:0] duty;
  logic        duty_valid;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pwm_duty_avg uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .step_end(step_end), .duty(duty), .duty_valid(duty_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap;
    int seen;
    int stab_bad;
    logic [31:0] prev;

    // R8: reset state
    repeat (4) @(negedge clk);
    check(duty == 0, "R8 duty in reset", duty, 0);
    check(duty_valid == 0 && step_end == 0, "R8 strobes in reset",
          {duty_valid, step_end}, 0);
    rst_n = 1'b1;

    // R3: first strobe in the K-th cycle, then every K cycles
    gap = 0;
    while (!step_end) begin gap++; @(negedge clk); end
    check(gap == K - 1, "R3 first step_end", gap, K - 1);
    @(negedge clk);
    check(duty_valid == 1, "R7 valid after step_end", duty_valid, 1);
    gap = 1;
    while (!step_end) begin gap++; @(negedge clk); end
    check(gap == K, "R3 step period", gap, K);

    // vector stream: align so bit 0 of each vector lands in cycle 0 of a step (R1)
    repeat (K - 1) @(negedge clk);
    seen = 0;
    stab_bad = 0;
    prev = duty;
    for (int j = 0; j < NV * K + K + 2; j++) begin
      if (duty_valid) begin
        if (j >= K + 2) begin
          int s;
          s = (j - K - 2) / K;
          check(((j - K - 2) % K) == 0, "R7 valid timing", j, K + 2 + s * K);
          if (s < NV)
            check(duty == V_DUTY[s], $sformatf("R1 R2 R4 R5 R6 vector %0d", s),
                  duty, V_DUTY[s]);
          seen++;
        end
      end else if (duty != prev) begin
        stab_bad++;
      end
      prev = duty;
      pwm_in = (j < NV * K) ? V_MASK[j / K][j % K] : 1'b0;
      @(negedge clk);
    end
    check(seen == NV, "R7 valid count", seen, NV);
    check(stab_bad == 0, "R7 duty held between updates", stab_bad, 0);

    // R8: reset while PWM high, then restart count
    pwm_in = 1'b1;
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(duty == 0 && duty_valid == 0, "R8 mid-run reset", duty, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    while (!duty_valid) @(negedge clk);
    // synchronizer restarts at 0: two of the first K cycles are not yet high (R1)
    check(duty == 3355443, "R1 R8 first step after reset", duty, 3355443);
    @(negedge clk);
    while (!duty_valid) @(negedge clk);
    check(duty == 4194304, "R6 full-high step", duty, 4194304);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule